// File: doc/BRIEF.md
# BCD Calendar Clock with Masked Alarm

This block keeps wall-clock time as six packed-BCD fields: seconds, minutes, hours, day of month, month (1 to 12) and a two-digit year (00 to 99). The year field is read as 2000 to 2099. An internal divider counts a slow clock-enable input, typically 32.768 kHz, and turns it into one step per second. Each step ripples carries through the fields, using the correct month length and the leap-year rule. A control byte starts and stops counting, and two test bits also stop it.

A second bank of six BCD registers holds an alarm time. Each alarm field has its own enable bit, and a global enable sits above them. After each one-second step the block compares only the enabled fields with the new time. When all of them match, it sets a sticky pending bit, which drives the interrupt output. Software clears that bit by writing a one to it.

All registers sit on a byte-wide bus with a write strobe and a combinational read port. A write to any time field lands on the next clock edge and restarts the sub-second divider.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01 of month 01 of year 00. The control byte, alarm values, alarm enables and pending bit all read 0, and `alarmIrq` is low.
- R2: Register addresses are as follows. 0 is control: bit0 run, bit1 count-select test, bit2 divider-reset test. 1..6 are the time fields seconds, minutes, hours, date, month, year. 7 is alarm control: bits 0..5 enable the fields in that same order, and bit6 is the global enable. 8..13 are the alarm values in the same field order. 14 is status, with bit0 pending. Unused bits and unused addresses read 0.
- R3: The time advances one second per TICKS_PER_SEC pulses of `tickEn`, and only while run=1 and both test bits are 0. Otherwise the time holds and stays readable and writable. The divider-reset bit also keeps the divider at zero.
- R4: Seconds and minutes wrap 59→00 and carry into the next field. Hours wrap 23→00 and carry into the date.
- R5: The date wraps to 01 after day 30 of months 04, 06, 09 and 11, and after day 31 of the other non-February months, carrying into the month.
- R6: February has 29 days when the year is divisible by 4 (00 included) and 28 days otherwise.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R8: A time write takes effect on the next clock edge and restarts the divider, so the next step needs a full TICKS_PER_SEC pulses.
- R9: On the clock cycle after a one-second step, if the global enable is set and every enabled field equals the new time, the pending bit is set. With no field enabled, every step matches.
- R10: A disabled field does not take part in the comparison. A mismatch in any enabled field, or a clear global enable, leaves the pending bit unchanged.
- R11: Writing status with bit0=1 clears the pending bit, and writing bit0=0 has no effect. A new match in the same cycle wins over the clear.
- R12: `alarmIrq` follows the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Slow-clock enable pulse counted by the divider |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| alarmIrq | output | 1 | Alarm interrupt, high while pending |

## Verification
The bench goes after the full rollover from 99-12-31 23:59:59. A carry chain that broke at any field would leave a stale date or year there. It also tests the last day of a 30-day month, and February in leap and non-leap years. A wrong month-length table would then skip a day or show day 29/31. A time write mid-second is followed by an almost full second of pulses. A divider that was not restarted would step early. For the alarm, the bench covers a mismatch only in an enabled field, a clear global enable, a setup with no enabled field, and a write of zero to the status bit. A comparator that ignored the masks, or a clear that did not decode bit0, would set or drop the interrupt at the wrong moment.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

  localparam int NUM_FIELDS = 6;

  localparam int FLD_SEC   = 0;
  localparam int FLD_MIN   = 1;
  localparam int FLD_HOUR  = 2;
  localparam int FLD_DATE  = 3;
  localparam int FLD_MONTH = 4;
  localparam int FLD_YEAR  = 5;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_TIME0  = 1;
  localparam int ADDR_ALMCTL = 7;
  localparam int ADDR_ALM0   = 8;
  localparam int ADDR_IRQ    = 14;

  localparam int CTL_RUN    = 0;
  localparam int CTL_CNTSEL = 1;
  localparam int CTL_DIVRST = 2;
  localparam int ALM_GLOBAL = 6;

  typedef struct packed {
    logic                  secStep;
    logic [NUM_FIELDS-1:0] timeWr;
    logic [NUM_FIELDS-1:0] almValWr;
    logic                  almCtlWr;
    logic                  irqClr;
    logic [7:0]            wrData;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] fieldCeil(input int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 8'h59;
      FLD_HOUR:         return 8'h23;
      FLD_DATE:         return 8'h31;
      FLD_MONTH:        return 8'h12;
      default:          return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] fieldFloor(input int idx);
    return ((idx == FLD_DATE) || (idx == FLD_MONTH)) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output calStrobe_t        strobe,
  output logic [2:0]        ctrlBits,
  output logic              running
);

  localparam int DIV_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_SEC - 1);

  logic [DIV_W-1:0] divQ;
  logic [2:0]       ctrlQ;
  logic             anyTimeWr;

  assign running  = ctrlQ[CTL_RUN] & ~ctrlQ[CTL_CNTSEL] & ~ctrlQ[CTL_DIVRST];
  assign ctrlBits = ctrlQ;

  always_comb begin
    strobe          = '0;
    strobe.wrData   = busWrData;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      strobe.timeWr[i]   = busWrEn && (busAddr == ADDR_W'(ADDR_TIME0 + i));
      strobe.almValWr[i] = busWrEn && (busAddr == ADDR_W'(ADDR_ALM0 + i));
    end
    strobe.almCtlWr = busWrEn && (busAddr == ADDR_W'(ADDR_ALMCTL));
    strobe.irqClr   = busWrEn && (busAddr == ADDR_W'(ADDR_IRQ)) && busWrData[0];
    anyTimeWr       = |strobe.timeWr;
    strobe.secStep  = running && tickEn && (divQ == DIV_LAST) && !anyTimeWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (busWrEn && (busAddr == ADDR_W'(ADDR_CTRL))) begin
      ctrlQ <= busWrData[2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
    end else if (anyTimeWr || ctrlQ[CTL_DIVRST]) begin
      divQ <= '0;
    end else if (running && tickEn) begin
      divQ <= (divQ == DIV_LAST) ? '0 : divQ + 1'b1;
    end
  end

endmodule

// File: rtl/calendar_datapath.sv
module calendar_datapath
  import calendar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  calStrobe_t              strobe,
  input  logic [2:0]              ctrlBits,
  input  logic [ADDR_W-1:0]       busAddr,
  output logic [7:0]              busRdData,
  output logic                    alarmIrq,
  output logic [8*NUM_FIELDS-1:0] timeVec,
  output logic                    almSet
);

  logic [NUM_FIELDS-1:0]   carry;
  logic [NUM_FIELDS-1:0]   fieldHit;
  logic [8*NUM_FIELDS-1:0] almVec;
  logic [NUM_FIELDS-1:0]   almEnQ;
  logic                    almGlobalQ;
  logic                    justStepped;
  logic                    pendingQ;
  logic [7:0]              dayCeil;

  assign carry[0] = strobe.secStep;
  assign dayCeil  = monthDays(timeVec[8*FLD_MONTH +: 8], timeVec[8*FLD_YEAR +: 8]);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [7:0] fieldQ;
    logic [7:0] alarmQ;
    logic [7:0] ceilVal;
    logic [7:0] nextVal;
    logic       atTop;

    assign ceilVal = (g == FLD_DATE) ? dayCeil : fieldCeil(g);
    assign atTop   = fieldQ >= ceilVal;
    assign nextVal = !carry[g] ? fieldQ : (atTop ? fieldFloor(g) : bcdInc(fieldQ));

    if (g < NUM_FIELDS - 1) begin : g_carry
      assign carry[g+1] = carry[g] & atTop;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 fieldQ <= fieldFloor(g);
      else if (strobe.timeWr[g]) fieldQ <= strobe.wrData;
      else                       fieldQ <= nextVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   alarmQ <= '0;
      else if (strobe.almValWr[g]) alarmQ <= strobe.wrData;
    end

    assign fieldHit[g]       = ~almEnQ[g] | (alarmQ == fieldQ);
    assign timeVec[8*g +: 8] = fieldQ;
    assign almVec[8*g +: 8]  = alarmQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almEnQ     <= '0;
      almGlobalQ <= 1'b0;
    end else if (strobe.almCtlWr) begin
      almEnQ     <= strobe.wrData[NUM_FIELDS-1:0];
      almGlobalQ <= strobe.wrData[ALM_GLOBAL];
    end
  end

  assign almSet = justStepped & almGlobalQ & (&fieldHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      justStepped <= 1'b0;
      pendingQ    <= 1'b0;
    end else begin
      justStepped <= strobe.secStep;
      if (almSet)             pendingQ <= 1'b1;
      else if (strobe.irqClr) pendingQ <= 1'b0;
    end
  end

  assign alarmIrq = pendingQ;

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL))   busRdData = {5'b0, ctrlBits};
    if (busAddr == ADDR_W'(ADDR_ALMCTL)) busRdData = {1'b0, almGlobalQ, almEnQ};
    if (busAddr == ADDR_W'(ADDR_IRQ))    busRdData = {7'b0, pendingQ};
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (busAddr == ADDR_W'(ADDR_TIME0 + i)) busRdData = timeVec[8*i +: 8];
      if (busAddr == ADDR_W'(ADDR_ALM0 + i))  busRdData = almVec[8*i +: 8];
    end
  end

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              alarmIrq
);

  calStrobe_t              strobe;
  logic [2:0]              ctrlBits;
  logic                    running;
  logic [8*NUM_FIELDS-1:0] timeVec;
  logic                    almSet;

  calendar_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .ADDR_W       (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strobe   (strobe),
    .ctrlBits (ctrlBits),
    .running  (running)
  );

  calendar_datapath #(
    .ADDR_W(ADDR_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ctrlBits (ctrlBits),
    .busAddr  (busAddr),
    .busRdData(busRdData),
    .alarmIrq (alarmIrq),
    .timeVec  (timeVec),
    .almSet   (almSet)
  );

endmodule

// File: rtl/bcd_calendar_rtc_chk.sv
module bcd_calendar_rtc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        running,
  input logic        secStep,
  input logic [5:0]  timeWr,
  input logic [7:0]  wrData,
  input logic [47:0] timeVec,
  input logic        pending,
  input logic        irqClr,
  input logic        almSet
);

  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    secStep |-> running); // R3

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!secStep && timeWr == 6'b0) |=> $stable(timeVec)); // R3

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (secStep && timeVec[7:0] == 8'h59) |=> (timeVec[7:0] == 8'h00)); // R4

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (secStep && timeVec == 48'h99_12_31_23_59_59) |=> (timeVec == 48'h00_01_01_00_00_00)); // R7

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    timeWr[0] |=> (timeVec[7:0] == $past(wrData))); // R8

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rstN)
    almSet |=> pending); // R9

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !almSet) |=> !pending); // R11

  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !irqClr) |=> pending); // R11

endmodule

bind bcd_calendar_rtc bcd_calendar_rtc_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .running(running),
  .secStep(strobe.secStep),
  .timeWr (strobe.timeWr),
  .wrData (strobe.wrData),
  .timeVec(timeVec),
  .pending(alarmIrq),
  .irqClr (strobe.irqClr),
  .almSet (almSet)
);

// File: tb/test_bcd_calendar_rtc.sv
module test_bcd_calendar_rtc;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       busWrEn = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       alarmIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int mCtl, mAlmCtl, mPend, mDiv, mStepped;
  int mT[6];
  int mAlm[6];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TICKS), .ADDR_W(4)) i_bcd_calendar_rtc (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .alarmIrq(alarmIrq)
  );

  function automatic int toBcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int fromBcd(input int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction

  function automatic int daysIn(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int modelRead(input int a);
    if (a == 0) return mCtl & 7;
    if (a >= 1 && a <= 6) return toBcd(mT[a-1]);
    if (a == 7) return mAlmCtl & 8'h7F;
    if (a >= 8 && a <= 13) return mAlm[a-8];
    if (a == 14) return mPend;
    return 0;
  endfunction

  function automatic string tagOf(input int a);
    if (a >= 1 && a <= 6) return "R3";
    if (a == 14) return "R11";
    return "R2";
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin : modelUpdate
    int running, timeWr, step, setIt, match, a, d;
    if (!rstN) begin
      mCtl = 0; mAlmCtl = 0; mPend = 0; mDiv = 0; mStepped = 0;
      mT = '{0, 0, 0, 1, 1, 0};
      mAlm = '{0, 0, 0, 0, 0, 0};
    end else begin
      a = busAddr; d = busWrData;
      running = ((mCtl & 1) != 0) && ((mCtl & 6) == 0);
      timeWr = busWrEn && a >= 1 && a <= 6;
      step = running && tickEn && (mDiv == TICKS - 1) && !timeWr;
      match = 1;
      for (int i = 0; i < 6; i++)
        if (((mAlmCtl >> i) & 1) != 0 && mAlm[i] != toBcd(mT[i])) match = 0;
      setIt = mStepped && (((mAlmCtl >> 6) & 1) != 0) && match;
      if (setIt) mPend = 1;
      else if (busWrEn && a == 14 && (d & 1) != 0) mPend = 0;
      if (timeWr || (mCtl & 4) != 0) mDiv = 0;
      else if (running && tickEn) mDiv = (mDiv == TICKS - 1) ? 0 : mDiv + 1;
      if (step) begin
        mT[0]++;
        if (mT[0] == 60) begin mT[0] = 0; mT[1]++; end
        if (mT[1] == 60) begin mT[1] = 0; mT[2]++; end
        if (mT[2] == 24) begin mT[2] = 0; mT[3]++; end
        if (mT[3] > daysIn(mT[4], mT[5])) begin mT[3] = 1; mT[4]++; end
        if (mT[4] > 12) begin mT[4] = 1; mT[5]++; end
        if (mT[5] > 99) mT[5] = 0;
      end
      if (busWrEn) begin
        if (a == 0) mCtl = d & 7;
        else if (a >= 1 && a <= 6) mT[a-1] = fromBcd(d);
        else if (a == 7) mAlmCtl = d & 8'h7F;
        else if (a >= 8 && a <= 13) mAlm[a-8] = d;
      end
      mStepped = step;
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      checks++;
      if (busRdData !== 8'(modelRead(busAddr))) begin
        errors++;
        $display("FAIL %s model addr=%0d actual=%02h expected=%02h", tagOf(busAddr), busAddr,
                 busRdData, modelRead(busAddr));
      end
      checks++;
      if (alarmIrq !== (mPend != 0)) begin
        errors++;
        $display("FAIL R12 model irq actual=%0b expected=%0d", alarmIrq, mPend);
      end
    end
  end

  task automatic busWrite(input int a, input int d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 4'(a); busWrData = 8'(d);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expectReg(input int a, input int exp, input string tag);
    @(negedge clk);
    busAddr = 4'(a);
    #2;
    checks++;
    if (busRdData !== 8'(exp)) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, busRdData, exp);
    end
  endtask

  task automatic expectIrq(input int exp, input string tag);
    @(negedge clk);
    #2;
    checks++;
    if (alarmIrq !== exp[0]) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0d", tag, alarmIrq, exp);
    end
  endtask

  task automatic runTicks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tickEn = 1'b1;
      busAddr = 4'(k % 16);
    end
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic setTime(input int y, input int mo, input int d, input int h, input int mi, input int s);
    busWrite(1, toBcd(s));
    busWrite(2, toBcd(mi));
    busWrite(3, toBcd(h));
    busWrite(4, toBcd(d));
    busWrite(5, toBcd(mo));
    busWrite(6, toBcd(y));
  endtask

  task automatic runSeconds(input int n);
    busWrite(0, 1);
    runTicks(n * TICKS);
    busWrite(0, 0);
  endtask

  task automatic finishRun;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg(1, 8'h00, "R1");
    expectReg(3, 8'h00, "R1");
    expectReg(4, 8'h01, "R1");
    expectReg(5, 8'h01, "R1");
    expectReg(14, 8'h00, "R1");
    expectIrq(0, "R1");

    // R2 register map and readback widths
    busWrite(10, 8'h17);
    expectReg(10, 8'h17, "R2");
    busWrite(7, 8'hFF);
    expectReg(7, 8'h7F, "R2");
    busWrite(7, 8'h00);
    busWrite(0, 8'hFF);
    expectReg(0, 8'h07, "R2");
    busWrite(0, 8'h00);
    expectReg(15, 8'h00, "R2");

    // R4 R5 R7 full rollover
    setTime(99, 12, 31, 23, 59, 58);
    runSeconds(2);
    expectReg(1, 8'h00, "R4");
    expectReg(2, 8'h00, "R4");
    expectReg(3, 8'h00, "R4");
    expectReg(4, 8'h01, "R5");
    expectReg(5, 8'h01, "R7");
    expectReg(6, 8'h00, "R7");

    // R5 thirty-day month
    setTime(23, 4, 30, 23, 59, 59);
    runSeconds(1);
    expectReg(4, 8'h01, "R5");
    expectReg(5, 8'h05, "R5");

    // R6 February lengths
    setTime(23, 2, 28, 23, 59, 59);
    runSeconds(1);
    expectReg(4, 8'h01, "R6");
    expectReg(5, 8'h03, "R6");
    setTime(24, 2, 28, 23, 59, 59);
    runSeconds(1);
    expectReg(4, 8'h29, "R6");
    expectReg(5, 8'h02, "R6");
    setTime(24, 2, 29, 23, 59, 59);
    runSeconds(1);
    expectReg(4, 8'h01, "R6");
    setTime(0, 2, 28, 23, 59, 59);
    runSeconds(1);
    expectReg(4, 8'h29, "R6");

    // R3 test bits hold the count
    setTime(10, 6, 15, 12, 30, 45);
    busWrite(0, 3);
    runTicks(3 * TICKS);
    expectReg(1, 8'h45, "R3");
    busWrite(0, 5);
    runTicks(3 * TICKS);
    expectReg(1, 8'h45, "R3");
    busWrite(2, 8'h31);
    expectReg(2, 8'h31, "R3");
    busWrite(0, 0);
    runSeconds(1);
    expectReg(1, 8'h46, "R3");

    // R8 write restarts the divider
    setTime(10, 6, 15, 12, 30, 10);
    busWrite(0, 1);
    runTicks(2);
    busWrite(1, 8'h20);
    runTicks(TICKS - 1);
    expectReg(1, 8'h20, "R8");
    runTicks(1);
    expectReg(1, 8'h21, "R8");
    busWrite(0, 0);

    // R9 R12 seconds-only alarm
    busWrite(8, 8'h05);
    busWrite(7, 8'h41);
    setTime(10, 6, 15, 0, 0, 3);
    runSeconds(2);
    expectReg(14, 8'h01, "R9");
    expectIrq(1, "R12");

    // R11 write-one-to-clear
    busWrite(14, 8'h00);
    expectReg(14, 8'h01, "R11");
    busWrite(14, 8'h01);
    expectReg(14, 8'h00, "R11");
    expectIrq(0, "R12");

    // R10 enabled field mismatches
    busWrite(9, 8'h07);
    busWrite(7, 8'h43);
    setTime(10, 6, 15, 0, 0, 3);
    runSeconds(3);
    expectReg(14, 8'h00, "R10");

    // R10 global enable clear
    busWrite(7, 8'h01);
    setTime(10, 6, 15, 0, 0, 3);
    runSeconds(3);
    expectReg(14, 8'h00, "R10");

    // R9 no field enabled: every step matches
    busWrite(7, 8'h40);
    runSeconds(1);
    expectReg(14, 8'h01, "R9");
    busWrite(14, 8'h01);
    expectReg(14, 8'h00, "R11");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule